// File: doc/BRIEF.md
# Serial Sampling-ADC Conversion Controller

This block runs one conversion on a serial sampling ADC that has a three-wire link: a conversion-control output, a serial clock output and a data input. When the DATA line is not driven it floats high through an external pull-up. On a start request the controller drives the conversion-control line low, which puts the converter in hold. After a short, parameterised lead time it starts a serial clock, derived by dividing the system clock.

The controller does not count a fixed number of clocks after the hold edge. It samples DATA on each rising serial clock edge and waits for the first LOW. That LOW marks the real start of conversion. The bits that follow are the result, most significant bit first. So if the converter's start moves by one clock, the data still line up.

After the last bit the controller lets the serial clock finish its high phase and stops it low. In the same cycle it raises the conversion-control line, returns the converter to sampling and presents the result together with a one-cycle done pulse. If no start LOW arrives within a set number of serial clocks, the controller releases the converter in the same way and pulses a timeout flag instead.

Top module: `sadc_conv_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are conv_o = 1, sclk_o = 0, busy_o = 0, done_o = 0, timeout_o = 0 and result_o = 0.
- R2: A start_i sampled high while busy_o = 0 drives conv_o low and busy_o high in the next cycle, with sclk_o still low.
- R3: The first rising edge of sclk_o comes exactly LEAD_CYC + DIV_HALF system cycles after conv_o falls.
- R4: While the serial clock runs, each high phase and each low phase between two high phases lasts exactly DIV_HALF system cycles. Between conversions sclk_o stays low.
- R5: sdata_i is sampled when sclk_o rises. The first sample that reads 0 is the start mark. The next RES_W samples form result_o, with the first of them placed in the MSB. This holds however many high samples come before the start mark, up to the timeout limit.
- R6: When a conversion ends normally, done_o is high for exactly one cycle. In that same cycle result_o holds the new value, conv_o is 1 and busy_o is 0. sclk_o falls in that same cycle.
- R7: If START_TMO rising-edge samples read 1 before any sample reads 0, timeout_o pulses for one cycle instead of done_o. conv_o returns to 1 and result_o keeps its previous value. START_TMO - 1 high samples followed by a 0 still gives a normal result.
- R8: A start_i request while busy_o = 1 is ignored. After the current conversion ends, busy_o stays 0.
- R9: While conv_o = 1, sdata_i has no effect. A LOW on it causes no busy, no clock, no done, no timeout and no change to the result.
- R10: sclk_o is never high while conv_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, sampled only while idle |
| sdata_i | input | 1 | Serial data from the converter, pulled high when floating |
| conv_o | output | 1 | Conversion control: low holds the sample, high returns to sampling |
| sclk_o | output | 1 | Gated serial clock, low when idle |
| busy_o | output | 1 | High from an accepted start until the converter is released |
| done_o | output | 1 | One-cycle pulse with a new result |
| timeout_o | output | 1 | One-cycle pulse when no start mark arrived |
| result_o | output | RES_W | Last captured conversion result |

## Verification
The converter model in the bench drives DATA after falling serial-clock edges. It holds DATA high for a chosen number of clocks before the start LOW. The data words are all zeros, all ones, alternating patterns and values with a single 1 at either end. Different lead counts show that the start-mark alignment, not a fixed clock count, sets where the word falls in the result. The data patterns show the bit order and that no bit is lost at either end. A lead of START_TMO - 1 against one of START_TMO separates the last accepted start from the first timeout. A stray start while busy and a LOW on DATA while idle show that the controller ignores inputs outside its window.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_TAIL  = 3'd4
  } sadc_state_e;

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int DIV_HALF = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] TERM = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          at_term;

  assign at_term = (cnt_q == TERM);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (at_term) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = run_i && at_term && !sclk_q;
  assign fall_o = run_i && at_term && sclk_q;

  AST_SCLK_RISE_ON_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> ($past(cnt_q) == TERM) && $past(run_i)); // R4
  AST_SCLK_FALL_ON_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> ($past(cnt_q) == TERM)); // R4

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             load_i,
  input  logic             sdata_i,
  output logic             last_o,
  output logic [RES_W-1:0] result_o
);

  localparam int BW = $clog2(RES_W + 1);
  localparam logic [BW-1:0] LAST = BW'(RES_W - 1);
  localparam logic [BW-1:0] FULL = BW'(RES_W);

  logic [RES_W-1:0] sh_q, sh_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [BW-1:0]    cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    res_d = res_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (shift_i) begin
      sh_d  = {sh_q[RES_W-2:0], sdata_i};
      cnt_d = cnt_q + 1'b1;
    end
    if (load_i) begin
      res_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      res_q <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      res_q <= res_d;
      cnt_q <= cnt_d;
    end
  end

  assign last_o   = (cnt_q == LAST);
  assign result_o = res_q;

  AST_LOAD_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_q == FULL)); // R5
  AST_NO_SHIFT_PAST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (cnt_q < FULL)); // R5

endmodule

// File: rtl/sadc_ctrl_fsm.sv
module sadc_ctrl_fsm
  import sadc_pkg::*;
#(
  parameter int LEAD_CYC  = 2,
  parameter int START_TMO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sdata_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic last_i,
  output logic run_o,
  output logic conv_o,
  output logic busy_o,
  output logic clr_o,
  output logic shift_o,
  output logic load_o,
  output logic done_o,
  output logic tmo_o
);

  localparam int LW = $clog2(LEAD_CYC + 1);
  localparam int TW = $clog2(START_TMO + 1);
  localparam logic [LW-1:0] LEAD_LAST = LW'(LEAD_CYC - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(START_TMO - 1);
  localparam logic [TW-1:0] TMO_LIM   = TW'(START_TMO);

  sadc_state_e   state_q, state_d;
  logic [LW-1:0] lead_q, lead_d;
  logic [TW-1:0] tmo_cnt_q, tmo_cnt_d;
  logic          err_q, err_d;
  logic          done_q, done_d;
  logic          tmo_q, tmo_d;

  always_comb begin
    state_d   = state_q;
    lead_d    = lead_q;
    tmo_cnt_d = tmo_cnt_q;
    err_d     = err_q;
    done_d    = 1'b0;
    tmo_d     = 1'b0;
    clr_o     = 1'b0;
    shift_o   = 1'b0;
    load_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_LEAD;
          lead_d    = '0;
          tmo_cnt_d = '0;
          err_d     = 1'b0;
          clr_o     = 1'b1;
        end
      end
      ST_LEAD: begin
        if (lead_q == LEAD_LAST) begin
          state_d = ST_WAIT;
        end else begin
          lead_d = lead_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (rise_i) begin
          if (!sdata_i) begin
            state_d = ST_SHIFT;
          end else if (tmo_cnt_q == TMO_LAST) begin
            state_d = ST_TAIL;
            err_d   = 1'b1;
          end else begin
            tmo_cnt_d = tmo_cnt_q + 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        if (rise_i) begin
          shift_o = 1'b1;
          if (last_i) begin
            state_d = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        if (fall_i) begin
          state_d = ST_IDLE;
          if (err_q) begin
            tmo_d = 1'b1;
          end else begin
            done_d = 1'b1;
            load_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lead_q    <= '0;
      tmo_cnt_q <= '0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      lead_q    <= lead_d;
      tmo_cnt_q <= tmo_cnt_d;
      err_q     <= err_d;
      done_q    <= done_d;
      tmo_q     <= tmo_d;
    end
  end

  assign run_o  = (state_q == ST_WAIT) || (state_q == ST_SHIFT) || (state_q == ST_TAIL);
  assign conv_o = (state_q == ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign tmo_o  = tmo_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_TMO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> !tmo_q); // R7
  AST_DONE_EXCLUDES_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && tmo_q)); // R7
  AST_TMO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (tmo_cnt_q < TMO_LIM)); // R7
  AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT || state_q == ST_SHIFT || state_q == ST_TAIL) |=> (state_q != ST_LEAD)); // R8
  AST_NO_CLOCK_IN_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEAD) |-> !rise_i && !fall_i); // R3

endmodule

// File: rtl/sadc_conv_ctrl.sv
module sadc_conv_ctrl #(
  parameter int RES_W     = 12,
  parameter int DIV_HALF  = 7,
  parameter int LEAD_CYC  = 2,
  parameter int START_TMO = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sdata_i,
  output logic             conv_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [RES_W-1:0] result_o
);

  logic rst_meta_q, rst_sync_q;
  logic run, rise, fall, last_bit;
  logic clr, shift, load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sadc_sclk_gen #(
    .DIV_HALF (DIV_HALF)
  ) u_sclk_gen (
    .clk    (clk_i),
    .rst_n  (rst_sync_q),
    .run_i  (run),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  sadc_capture #(
    .RES_W (RES_W)
  ) u_capture (
    .clk      (clk_i),
    .rst_n    (rst_sync_q),
    .clr_i    (clr),
    .shift_i  (shift),
    .load_i   (load),
    .sdata_i  (sdata_i),
    .last_o   (last_bit),
    .result_o (result_o)
  );

  sadc_ctrl_fsm #(
    .LEAD_CYC  (LEAD_CYC),
    .START_TMO (START_TMO)
  ) u_ctrl_fsm (
    .clk     (clk_i),
    .rst_n   (rst_sync_q),
    .start_i (start_i),
    .sdata_i (sdata_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .last_i  (last_bit),
    .run_o   (run),
    .conv_o  (conv_o),
    .busy_o  (busy_o),
    .clr_o   (clr),
    .shift_o (shift),
    .load_o  (load),
    .done_o  (done_o),
    .tmo_o   (timeout_o)
  );

  AST_SCLK_ONLY_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    sclk_o |-> !conv_o); // R10
  AST_DONE_RELEASES_CONV: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    done_o |-> conv_o && !busy_o && !sclk_o); // R6
  AST_IDLE_IGNORES_DATA: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (conv_o && !start_i) |=> conv_o && !done_o && !timeout_o && $stable(result_o)); // R9
  AST_START_ENTERS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (conv_o && start_i) |=> !conv_o && busy_o && !sclk_o); // R2

endmodule

// File: tb/sadc_conv_ctrl_bench.sv
module sadc_conv_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 12;
  localparam int DIV_HALF   = 7;
  localparam int LEAD_CYC   = 2;
  localparam int START_TMO  = 8;

  typedef struct packed {
    logic [7:0]       lag;
    logic [RES_W-1:0] val;
    logic             tmo;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{8'd1, 12'hA5C, 1'b0},
    '{8'd3, 12'h000, 1'b0},
    '{8'd2, 12'hFFF, 1'b0},
    '{8'd7, 12'h801, 1'b0},
    '{8'd8, 12'h123, 1'b1},
    '{8'd4, 12'h555, 1'b0},
    '{8'd5, 12'hAAA, 1'b0},
    '{8'd1, 12'h001, 1'b0}
  };

  logic             clk;
  logic             rst_ni;
  logic             start_i;
  logic             sdata_i;
  logic             conv_o, sclk_o, busy_o, done_o, timeout_o;
  logic [RES_W-1:0] result_o;

  int n_chk  = 0;
  int n_fail = 0;

  int               m_lag = 1;
  logic [RES_W-1:0] m_val = '0;
  int               fcnt  = 0;
  logic             drv   = 1'b1;
  logic             force_low = 1'b0;
  bit               mon_on = 1'b0;

  sadc_conv_ctrl #(
    .RES_W     (RES_W),
    .DIV_HALF  (DIV_HALF),
    .LEAD_CYC  (LEAD_CYC),
    .START_TMO (START_TMO)
  ) u_sadc_conv_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sdata_i   (sdata_i),
    .conv_o    (conv_o),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .result_o  (result_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Converter model: floats high (pull-up) until the start LOW after fall m_lag,
  // then one data bit, MSB first, after each later falling edge.
  always @(negedge sclk_o or posedge conv_o) begin
    if (conv_o) begin
      fcnt = 0;
      drv  = 1'b1;
    end else begin
      fcnt = fcnt + 1;
      if (fcnt == m_lag)
        drv = 1'b0;
      else if (fcnt > m_lag && fcnt <= m_lag + RES_W)
        drv = m_val[RES_W - 1 - (fcnt - m_lag - 1)];
      else if (fcnt > m_lag + RES_W)
        drv = 1'b0;
    end
  end

  assign sdata_i = force_low ? 1'b0 : (conv_o ? 1'b1 : drv);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Phase-length and clock-gating monitor (R4, R10)
  bit prev_s = 1'b0;
  int run_len = 0;
  bit seen_rise = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (sclk_o !== prev_s) begin
        if (prev_s)
          chk(run_len == DIV_HALF, "R4 high phase length", run_len, DIV_HALF);
        else if (seen_rise)
          chk(run_len == DIV_HALF, "R4 low phase length", run_len, DIV_HALF);
        if (sclk_o) seen_rise = 1'b1;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (conv_o) seen_rise = 1'b0;
      if (sclk_o) chk(!conv_o, "R10 sclk high while conv high", conv_o, 0);
      prev_s = sclk_o;
    end
  end

  task automatic run_conv(input int lag, input logic [RES_W-1:0] val, input bit exp_tmo);
    int n;
    logic [RES_W-1:0] prev_res;
    m_lag = lag;
    m_val = val;
    prev_res = result_o;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(!conv_o && busy_o && !sclk_o, "R2 start enters hold", {conv_o, busy_o, sclk_o}, 3'b010);
    n = 0;
    while (!sclk_o && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == LEAD_CYC + DIV_HALF, "R3 lead to first rise", n, LEAD_CYC + DIV_HALF);
    n = 0;
    while (!done_o && !timeout_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (exp_tmo) begin
      chk(timeout_o && !done_o, "R7 timeout pulse", {done_o, timeout_o}, 2'b01);
      chk(result_o == prev_res, "R7 result kept", result_o, prev_res);
      chk(conv_o && !busy_o, "R7 conv released", {conv_o, busy_o}, 2'b10);
    end else begin
      chk(done_o && !timeout_o, "R6 done pulse", {done_o, timeout_o}, 2'b10);
      chk(result_o == val, "R5 captured word", result_o, val);
      chk(conv_o && !busy_o && !sclk_o, "R6 released with done", {conv_o, busy_o, sclk_o}, 3'b100);
    end
    @(negedge clk);
    chk(!done_o && !timeout_o, "R6 R7 single-cycle pulse", {done_o, timeout_o}, 2'b00);
  endtask

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(conv_o && !sclk_o && !busy_o && !done_o && !timeout_o && result_o == '0,
        "R1 state in reset", {conv_o, sclk_o, busy_o, done_o, timeout_o}, 5'b10000);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(conv_o && !sclk_o && !busy_o && !done_o && !timeout_o && result_o == '0,
        "R1 state after release", {conv_o, sclk_o, busy_o, done_o, timeout_o}, 5'b10000);
    mon_on = 1'b1;

    // Table walk: R5 lag/pattern variety, R7 boundary at lags 7 and 8
    for (int i = 0; i < NVEC; i++) begin
      run_conv(int'(TBL[i].lag), TBL[i].val, TBL[i].tmo);
      repeat (3) @(negedge clk);
    end

    // R8: stray start requests during a conversion
    fork
      run_conv(3, 12'h6B9, 1'b0);
      begin
        repeat (40) @(negedge clk);
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
      end
    join
    repeat (2) @(negedge clk);
    chk(!busy_o && conv_o, "R8 start while busy ignored", {busy_o, conv_o}, 2'b01);

    // R9: LOW on DATA while idle
    force_low = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(!busy_o && conv_o && !sclk_o && !done_o && !timeout_o,
          "R9 idle ignores data", {busy_o, conv_o, sclk_o, done_o, timeout_o}, 5'b01000);
    end
    chk(result_o == 12'h6B9, "R9 result unchanged", result_o, 12'h6B9);
    force_low = 1'b0;

    // Back-to-back start immediately after done (R2)
    run_conv(2, 12'h3C3, 1'b0);
    run_conv(6, 12'hC3C, 1'b0);

    repeat (5) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

endmodule